// File: doc/BRIEF.md
# Pulse-Charge Lithium Cell Charge Sequencer

This block is the control state machine of a single-cell lithium charger. The charger gates an external current-limited source. The block reads digitised cell voltage and temperature samples, a flag that says whether the source is present, and command strobes from a host. It drives two active-low gate outputs. The first is a recovery output that passes a small trickle current into a deeply discharged cell. The second is a fast-charge output that switches the full source current.

Fast charge begins in a bulk phase, with the fast gate held on. A short periodic release of the gate gives the surrounding circuit a chance to notice that the source has been unplugged. Once the cell reaches the charge-voltage threshold, the block moves to pulse charging. Each on-pulse has a fixed length. After it, the block times how long the cell takes to sag back below the threshold. When the cell stays above the threshold for a set number of whole pulse periods, the charge is finished. Two further rules also end a charge: an over-temperature limit and a countdown charge-time register.

All intervals are counted in ticks of an external 1 ms strobe. The interval lengths are parameters, so a testbench can compress time.

Top module: `lchg_charge_seq`

## Requirements
- R1: `trickle_n` is driven low one clock after `src_ok`=1, `volt_vld`=1 and `volt` < V_LB all hold. This does not depend on temperature, charge state or `init_sel`. `trickle_n` returns high once `volt` >= V_LB.
- R2: A `cmd_start` strobe while idle arms a fast charge. A rising edge of `src_ok` also arms a fast charge, but only when `init_sel`=1; with `init_sel`=0 a source appearing arms nothing.
- R3: An armed charge does not start while any of the following holds: the temperature is outside T_LOW..T_HIGH inclusive, `src_ok`=0, either sample is not valid, or `volt` < V_LB. It starts once none of these holds.
- R4: In the bulk phase, `fast_n` is low except during the last PROBE_OFF_MS of every PROBE_PERIOD_MS ms, when it is released high.
- R5: When `volt` >= V_CV in the bulk phase, the block enters the pulse region. There `fast_n` is held low without probing for PULSE_MS ms and then goes high. If `volt` then drops below V_CV while `fast_n` is off, `fast_n` goes low again and a new PULSE_MS on-pulse starts.
- R6: If the off time after a pulse reaches DECAY_PERIODS whole periods of PULSE_MS ms, the charge completes with status done.
- R7: While charging, a valid temperature above T_MAX ends the charge with status done and `fast_n` high.
- R8: `ctr_value` is loaded from `ctr_preset` when fast charge starts, and it decrements once every CTR_STEP_MS ms while charging. When it reaches zero, the charge completes with status done. A `ctr_wr` strobe overwrites the counter at any time and takes priority over the load and the decrement.
- R9: `status` encodes the state as follows: 2'b00 means no source; 2'b01 means charging (fast charge, or trickle active); 2'b10 means the source is present but there is no charge; 2'b11 means done. The done code holds until a `stat_wr` strobe, which returns the block to idle.
- R10: A `cmd_stop` strobe or loss of `src_ok` during charge returns the block to idle with `fast_n` high and without setting done. A new start or a new arming edge is then needed.
- R11: After reset, `trickle_n`=1, `fast_n`=1, `status`=2'b00 and `ctr_value`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| volt | input | VW | Cell voltage sample, unsigned, 4.88 mV per LSB |
| volt_vld | input | 1 | Voltage sample valid |
| temp | input | TW | Temperature sample, two's complement, 0.125 C per LSB |
| temp_vld | input | 1 | Temperature sample valid |
| src_ok | input | 1 | Charge source present |
| cmd_start | input | 1 | Start-charge strobe |
| cmd_stop | input | 1 | Stop-charge strobe |
| stat_wr | input | 1 | Status write strobe, clears done |
| init_sel | input | 1 | 1: a source appearing also arms a charge |
| ctr_preset | input | CW | Charge-time preset loaded at fast-charge start |
| ctr_wr | input | 1 | Charge-time counter write strobe |
| ctr_wdata | input | CW | Charge-time counter write data |
| trickle_n | output | 1 | Active-low trickle recovery gate |
| fast_n | output | 1 | Active-low fast-charge gate |
| status | output | 2 | Charge status code |
| ctr_value | output | CW | Charge-time counter value |

## Verification
The bench builds the block with compressed intervals: an 8 ms pulse, a 6 ms probe period with 3 ms off, a 20 ms counter step and 3 decay periods. It holds `ms_tick` high every clock. With these settings, a full pulse-and-decay termination, several counter steps and ten probe cycles each fit in a few dozen clocks, so each can be timed against exact windows. The voltage and temperature thresholds keep their default values, so the samples the bench applies use real-unit encodings.

// File: rtl/lchg_pkg.sv
package lchg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_BULK = 3'd2,
        ST_PON  = 3'd3,
        ST_POFF = 3'd4,
        ST_DONE = 3'd5
    } chg_state_e;

    typedef enum logic [1:0] {
        STAT_NOSRC = 2'b00,
        STAT_CHG   = 2'b01,
        STAT_SRC   = 2'b10,
        STAT_DONE  = 2'b11
    } chg_stat_e;

    typedef struct packed {
        logic src;        // source present
        logic meas_ok;    // both samples valid
        logic above_lb;   // volt >= low-battery threshold
        logic at_cv;      // volt >= charge-voltage threshold
        logic temp_win;   // temperature within start window
        logic temp_hot;   // valid temperature above the limit
        logic trickle;    // recovery current requested
    } cell_cond_t;

    function automatic logic is_charging(chg_state_e s);
        return (s == ST_BULK) || (s == ST_PON) || (s == ST_POFF);
    endfunction

endpackage

// File: rtl/lchg_cond.sv
module lchg_cond
    import lchg_pkg::*;
#(
    parameter int VW     = 10,
    parameter int TW     = 11,
    parameter int V_LB   = 615,
    parameter int V_CV   = 861,
    parameter int T_LOW  = 0,
    parameter int T_HIGH = 320,
    parameter int T_MAX  = 400
) (
    input  logic [VW-1:0]        volt,
    input  logic                 volt_vld,
    input  logic signed [TW-1:0] temp,
    input  logic                 temp_vld,
    input  logic                 src_ok,
    output cell_cond_t           cond
);
    localparam logic [VW-1:0]        VLB_C = VW'(V_LB);
    localparam logic [VW-1:0]        VCV_C = VW'(V_CV);
    localparam logic signed [TW-1:0] TLO_C = TW'(T_LOW);
    localparam logic signed [TW-1:0] THI_C = TW'(T_HIGH);
    localparam logic signed [TW-1:0] TMX_C = TW'(T_MAX);

    always_comb begin
        cond.src      = src_ok;
        cond.meas_ok  = volt_vld && temp_vld;
        cond.above_lb = volt_vld && (volt >= VLB_C);
        cond.at_cv    = volt_vld && (volt >= VCV_C);
        cond.temp_win = temp_vld && (temp >= TLO_C) && (temp <= THI_C);
        cond.temp_hot = temp_vld && (temp > TMX_C);
        cond.trickle  = src_ok && volt_vld && (volt < VLB_C);
    end
endmodule

// File: rtl/lchg_timebase.sv
module lchg_timebase #(
    parameter int PROBE_PERIOD_MS = 55,
    parameter int PROBE_OFF_MS    = 27,
    parameter int CTR_STEP_MS     = 56000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic ms_tick,
    output logic probe_off,
    output logic step
);
    localparam int PW = (PROBE_PERIOD_MS > 1) ? $clog2(PROBE_PERIOD_MS) : 1;
    localparam int SW = (CTR_STEP_MS > 1) ? $clog2(CTR_STEP_MS) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(PROBE_PERIOD_MS - 1);
    localparam logic [PW-1:0] PH_OFF  = PW'(PROBE_PERIOD_MS - PROBE_OFF_MS);
    localparam logic [SW-1:0] ST_LAST = SW'(CTR_STEP_MS - 1);

    logic [PW-1:0] phase;
    logic [SW-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (ms_tick) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            scnt <= '0;
        end else if (ms_tick) begin
            scnt <= (scnt == ST_LAST) ? '0 : scnt + 1'b1;
        end
    end

    assign probe_off = run && (phase >= PH_OFF);
    assign step      = run && ms_tick && (scnt == ST_LAST);

    assert_phase_range_R4: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_LAST);

    assert_idle_clear_R4: assert property (@(posedge clk) disable iff (rst)
        !run |=> (phase == '0));
endmodule

// File: rtl/lchg_ctr.sv
module lchg_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] preset,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          step,
    output logic [CW-1:0] value,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end else if (load) begin
            value <= preset;
        end else if (step && (value != '0)) begin
            value <= value - 1'b1;
        end
    end

    assign zero = (value == '0);

    assert_ctr_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr && !load && !step) |=> $stable(value));

    assert_ctr_dec_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr && !load && step && (value != '0)) |=> (value == $past(value) - 1'b1));

    assert_ctr_load_R8: assert property (@(posedge clk) disable iff (rst)
        (!wr && load) |=> (value == $past(preset)));

    assert_ctr_write_R8: assert property (@(posedge clk) disable iff (rst)
        wr |=> (value == $past(wdata)));
endmodule

// File: rtl/lchg_seq.sv
module lchg_seq
    import lchg_pkg::*;
#(
    parameter int PULSE_MS      = 875,
    parameter int DECAY_PERIODS = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  cell_cond_t cond,
    input  logic       cmd_start,
    input  logic       cmd_stop,
    input  logic       stat_wr,
    input  logic       init_sel,
    input  logic       probe_off,
    input  logic       ctr_zero,
    output chg_state_e state,
    output logic       ctr_load,
    output logic       trickle_n,
    output logic       fast_n,
    output logic [1:0] status
);
    localparam int PCW = (PULSE_MS > 1) ? $clog2(PULSE_MS) : 1;
    localparam int DCW = $clog2(DECAY_PERIODS + 1);
    localparam logic [PCW-1:0] P_LAST = PCW'(PULSE_MS - 1);
    localparam logic [DCW-1:0] D_LAST = DCW'(DECAY_PERIODS - 1);

    chg_state_e     state_q, state_d;
    logic [PCW-1:0] pcnt_q, pcnt_d;
    logic [DCW-1:0] dcnt_q, dcnt_d;
    logic           src_q;
    logic           arm_req, start_ok, charging;

    assign charging = is_charging(state_q);
    assign arm_req  = cmd_start || (init_sel && cond.src && !src_q);
    assign start_ok = cond.src && cond.meas_ok && cond.temp_win && cond.above_lb;

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        dcnt_d  = dcnt_q;
        unique case (state_q)
            ST_IDLE: if (arm_req) state_d = ST_WAIT;
            ST_WAIT: begin
                if (cmd_stop) state_d = ST_IDLE;
                else if (start_ok) state_d = ST_BULK;
            end
            ST_BULK, ST_PON, ST_POFF: begin
                if (cmd_stop || !cond.src) begin
                    state_d = ST_IDLE;
                end else if (cond.temp_hot || ctr_zero) begin
                    state_d = ST_DONE;
                end else if (state_q == ST_BULK) begin
                    if (cond.at_cv) begin
                        state_d = ST_PON;
                        pcnt_d  = '0;
                    end
                end else if (state_q == ST_PON) begin
                    if (ms_tick) begin
                        if (pcnt_q == P_LAST) begin
                            state_d = ST_POFF;
                            pcnt_d  = '0;
                            dcnt_d  = '0;
                        end else begin
                            pcnt_d = pcnt_q + 1'b1;
                        end
                    end
                end else begin
                    if (!cond.at_cv) begin
                        state_d = ST_PON;
                        pcnt_d  = '0;
                    end else if (ms_tick) begin
                        if (pcnt_q == P_LAST) begin
                            pcnt_d = '0;
                            if (dcnt_q == D_LAST) state_d = ST_DONE;
                            else dcnt_d = dcnt_q + 1'b1;
                        end else begin
                            pcnt_d = pcnt_q + 1'b1;
                        end
                    end
                end
            end
            ST_DONE: if (stat_wr) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign ctr_load = (state_q == ST_WAIT) && (state_d == ST_BULK);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
            dcnt_q  <= '0;
            src_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            dcnt_q  <= dcnt_d;
            src_q   <= cond.src;
        end
    end

    // registered pin drivers
    always_ff @(posedge clk) begin
        if (rst) begin
            trickle_n <= 1'b1;
            fast_n    <= 1'b1;
            status    <= STAT_NOSRC;
        end else begin
            trickle_n <= !cond.trickle;
            fast_n    <= !((state_q == ST_PON) || ((state_q == ST_BULK) && !probe_off));
            if (state_q == ST_DONE)               status <= STAT_DONE;
            else if (charging || cond.trickle)    status <= STAT_CHG;
            else if (cond.src)                    status <= STAT_SRC;
            else                                  status <= STAT_NOSRC;
        end
    end

    assign state = state_q;

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_DONE) && !stat_wr) |=> (state_q == ST_DONE));

    assert_done_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (status == STAT_DONE) |-> fast_n);

    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (charging && (cmd_stop || !cond.src)) |=> (state_q == ST_IDLE));

    assert_hot_done_R7: assert property (@(posedge clk) disable iff (rst)
        (charging && !cmd_stop && cond.src && cond.temp_hot) |=> (state_q == ST_DONE));

    assert_ctr_end_R8: assert property (@(posedge clk) disable iff (rst)
        (charging && !cmd_stop && cond.src && ctr_zero) |=> (state_q == ST_DONE));

    assert_hold_off_R3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_WAIT) && !start_ok) |=> (state_q != ST_BULK));
endmodule

// File: rtl/lchg_charge_seq.sv
module lchg_charge_seq
    import lchg_pkg::*;
#(
    parameter int VW              = 10,
    parameter int TW              = 11,
    parameter int CW              = 8,
    parameter int V_LB            = 615,
    parameter int V_CV            = 861,
    parameter int T_LOW           = 0,
    parameter int T_HIGH          = 320,
    parameter int T_MAX           = 400,
    parameter int PULSE_MS        = 875,
    parameter int DECAY_PERIODS   = 15,
    parameter int PROBE_PERIOD_MS = 55,
    parameter int PROBE_OFF_MS    = 27,
    parameter int CTR_STEP_MS     = 56000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ms_tick,
    input  logic [VW-1:0]        volt,
    input  logic                 volt_vld,
    input  logic signed [TW-1:0] temp,
    input  logic                 temp_vld,
    input  logic                 src_ok,
    input  logic                 cmd_start,
    input  logic                 cmd_stop,
    input  logic                 stat_wr,
    input  logic                 init_sel,
    input  logic [CW-1:0]        ctr_preset,
    input  logic                 ctr_wr,
    input  logic [CW-1:0]        ctr_wdata,
    output logic                 trickle_n,
    output logic                 fast_n,
    output logic [1:0]           status,
    output logic [CW-1:0]        ctr_value
);
    cell_cond_t cond;
    chg_state_e state;
    logic       probe_off, step, ctr_load, ctr_zero;

    lchg_cond #(
        .VW(VW), .TW(TW), .V_LB(V_LB), .V_CV(V_CV),
        .T_LOW(T_LOW), .T_HIGH(T_HIGH), .T_MAX(T_MAX)
    ) u_cond (
        .volt(volt), .volt_vld(volt_vld), .temp(temp), .temp_vld(temp_vld),
        .src_ok(src_ok), .cond(cond)
    );

    lchg_timebase #(
        .PROBE_PERIOD_MS(PROBE_PERIOD_MS), .PROBE_OFF_MS(PROBE_OFF_MS),
        .CTR_STEP_MS(CTR_STEP_MS)
    ) u_tb (
        .clk(clk), .rst(rst), .run(is_charging(state)), .ms_tick(ms_tick),
        .probe_off(probe_off), .step(step)
    );

    lchg_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .load(ctr_load), .preset(ctr_preset),
        .wr(ctr_wr), .wdata(ctr_wdata), .step(step),
        .value(ctr_value), .zero(ctr_zero)
    );

    lchg_seq #(.PULSE_MS(PULSE_MS), .DECAY_PERIODS(DECAY_PERIODS)) u_seq (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .cond(cond),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .stat_wr(stat_wr),
        .init_sel(init_sel), .probe_off(probe_off), .ctr_zero(ctr_zero),
        .state(state), .ctr_load(ctr_load), .trickle_n(trickle_n),
        .fast_n(fast_n), .status(status)
    );

    assert_trickle_pin_R1: assert property (@(posedge clk) disable iff (rst)
        (!src_ok || !volt_vld) |=> trickle_n);
endmodule

// File: tb/sim_lchg_charge_seq.sv
module sim_lchg_charge_seq;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ms_tick = 1'b1;
    logic [9:0]        volt;
    logic              volt_vld;
    logic signed [10:0] temp;
    logic              temp_vld;
    logic              src_ok, cmd_start, cmd_stop, stat_wr, init_sel;
    logic [7:0]        ctr_preset, ctr_wdata;
    logic              ctr_wr;
    logic              trickle_n, fast_n;
    logic [1:0]        status;
    logic [7:0]        ctr_value;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lchg_charge_seq #(
        .PULSE_MS(8), .DECAY_PERIODS(3), .PROBE_PERIOD_MS(6),
        .PROBE_OFF_MS(3), .CTR_STEP_MS(20)
    ) u0 (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .volt(volt), .volt_vld(volt_vld),
        .temp(temp), .temp_vld(temp_vld), .src_ok(src_ok), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .stat_wr(stat_wr), .init_sel(init_sel),
        .ctr_preset(ctr_preset), .ctr_wr(ctr_wr), .ctr_wdata(ctr_wdata),
        .trickle_n(trickle_n), .fast_n(fast_n), .status(status), .ctr_value(ctr_value)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_low(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!fast_n) c++;
        end
    endtask

    task automatic strobe_start();
        cmd_start = 1'b1; cyc(1); cmd_start = 1'b0;
    endtask

    task automatic do_reset();
        volt = 10'd700; volt_vld = 1'b1; temp = 11'sd200; temp_vld = 1'b1;
        src_ok = 1'b0; cmd_start = 1'b0; cmd_stop = 1'b0; stat_wr = 1'b0;
        init_sel = 1'b0; ctr_preset = 8'd255; ctr_wr = 1'b0; ctr_wdata = '0;
        rst = 1'b1; cyc(3); rst = 1'b0; cyc(1);
    endtask

    // bring the block into bulk charge
    task automatic go_bulk();
        src_ok = 1'b1; cyc(2); strobe_start(); cyc(3);
    endtask

    task automatic t_reset();
        do_reset();
        chk(trickle_n == 1'b1, "R11 trickle_n", trickle_n, 1);
        chk(fast_n == 1'b1, "R11 fast_n", fast_n, 1);
        chk(status == 2'b00, "R11 status", status, 0);
        chk(ctr_value == 8'd0, "R11 ctr_value", ctr_value, 0);
    endtask

    task automatic t_trickle();
        do_reset();
        src_ok = 1'b1; volt = 10'd500; temp = -11'sd80; cyc(3);
        chk(trickle_n == 1'b0, "R1 trickle low when cold and below V_LB", trickle_n, 0);
        chk(status == 2'b01, "R9 status during trickle", status, 1);
        volt = 10'd615; cyc(3);
        chk(trickle_n == 1'b1, "R1 trickle released at V_LB", trickle_n, 1);
        chk(status == 2'b10, "R9 status source present", status, 2);
        src_ok = 1'b0; volt = 10'd500; cyc(3);
        chk(trickle_n == 1'b1, "R1 no trickle without source", trickle_n, 1);
    endtask

    task automatic t_holdoff();
        int c;
        do_reset();
        src_ok = 1'b1; temp = -11'sd40; cyc(2); strobe_start();
        count_low(20, c);
        chk(c == 0, "R3 held off when too cold", c, 0);
        temp = 11'sd330; count_low(20, c);
        chk(c == 0, "R3 held off when too warm", c, 0);
        temp = 11'sd200; volt = 10'd600; count_low(20, c);
        chk(c == 0, "R3 held off below V_LB", c, 0);
        volt = 10'd700; temp_vld = 1'b0; count_low(20, c);
        chk(c == 0, "R3 held off with invalid sample", c, 0);
        temp_vld = 1'b1; count_low(12, c);
        chk(c > 0, "R3 starts once clear", c, 1);
        chk(status == 2'b01, "R9 status while charging", status, 1);
    endtask

    task automatic t_init_sel();
        int c;
        do_reset();
        init_sel = 1'b1; cyc(2); src_ok = 1'b1; count_low(12, c);
        chk(c > 0, "R2 source edge arms with init_sel=1", c, 1);
        do_reset();
        cyc(2); src_ok = 1'b1; count_low(20, c);
        chk(c == 0, "R2 source edge ignored with init_sel=0", c, 0);
        strobe_start(); count_low(12, c);
        chk(c > 0, "R2 start command arms", c, 1);
    endtask

    task automatic t_probe();
        int c;
        do_reset(); go_bulk();
        count_low(60, c);
        chk(c >= 28 && c <= 32, "R4 probe duty in bulk", c, 30);
    endtask

    task automatic t_pulse();
        int c, t;
        do_reset(); go_bulk(); cyc(5);
        volt = 10'd870; cyc(1);
        count_low(6, c);
        chk(c == 6, "R5 on-pulse held low without probe", c, 6);
        cyc(5);
        chk(fast_n == 1'b1, "R5 gate off after on-pulse", fast_n, 1);
        t = 12;
        while (status != 2'b11 && t < 60) begin cyc(1); t++; end
        chk(t >= 30 && t <= 40, "R6 decay termination time", t, 34);
        chk(fast_n == 1'b1, "R6 gate off when done", fast_n, 1);
    endtask

    task automatic t_repulse();
        do_reset(); go_bulk(); cyc(5);
        volt = 10'd870; cyc(14);
        chk(fast_n == 1'b1, "R5 off before sag", fast_n, 1);
        volt = 10'd850; cyc(3);
        chk(fast_n == 1'b0, "R5 re-pulse after sag", fast_n, 0);
        volt = 10'd870; cyc(28);
        chk(status == 2'b01, "R6 sag restarts decay window", status, 1);
        cyc(10);
        chk(status == 2'b11, "R6 done after restarted window", status, 3);
    endtask

    task automatic t_hot();
        do_reset(); go_bulk();
        chk(status == 2'b01, "R7 charging before heat", status, 1);
        temp = 11'sd410; cyc(3);
        chk(status == 2'b11, "R7 over-temperature done", status, 3);
        chk(fast_n == 1'b1, "R7 gate off", fast_n, 1);
        temp = 11'sd200; cyc(20);
        chk(status == 2'b11, "R9 done latched", status, 3);
        stat_wr = 1'b1; cyc(1); stat_wr = 1'b0; cyc(2);
        chk(status == 2'b10, "R9 status write clears done", status, 2);
    endtask

    task automatic t_ctr();
        do_reset();
        ctr_preset = 8'd2; go_bulk();
        chk(ctr_value == 8'd2, "R8 preset loaded at start", ctr_value, 2);
        cyc(20);
        chk(ctr_value == 8'd1, "R8 one decrement", ctr_value, 1);
        chk(status == 2'b01, "R8 still charging", status, 1);
        cyc(25);
        chk(status == 2'b11, "R8 zero count ends charge", status, 3);
        do_reset();
        ctr_preset = 8'd200; go_bulk(); cyc(2);
        ctr_wr = 1'b1; ctr_wdata = 8'd1; cyc(1); ctr_wr = 1'b0;
        chk(ctr_value == 8'd1, "R8 overwrite while charging", ctr_value, 1);
        cyc(25);
        chk(status == 2'b11, "R8 overwritten count ends charge", status, 3);
    endtask

    task automatic t_abort();
        int c;
        do_reset(); go_bulk();
        cmd_stop = 1'b1; cyc(1); cmd_stop = 1'b0; cyc(2);
        chk(status == 2'b10, "R10 stop leaves done clear", status, 2);
        count_low(30, c);
        chk(c == 0, "R10 no restart after stop", c, 0);
        do_reset(); go_bulk();
        src_ok = 1'b0; cyc(3);
        chk(status == 2'b00, "R10 source loss status", status, 0);
        chk(fast_n == 1'b1, "R10 gate off on source loss", fast_n, 1);
        src_ok = 1'b1; count_low(20, c);
        chk(c == 0, "R10 no restart on return with init_sel=0", c, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_trickle();
        t_holdoff();
        t_init_sel();
        t_probe();
        t_pulse();
        t_repulse();
        t_hot();
        t_ctr();
        t_abort();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule